// File: doc/BRIEF.md
# Lane-Striped Serial Transmit and Receive Pair

This block takes an N-bit word from a core and sends it as on-off keyed serial streams over a group of transmit lanes. Each lane stands for one optical wavelength. A lane mask picks which lanes are lit. Bits of the word are dealt in turn across the lit lanes, so a word with K lit lanes takes ceil(N/K) bit-times. Lanes that are off stay dark at 0 for the whole time, which saves energy.

A receive half rebuilds the word from the lane streams. It uses the same allocation rule and the mask that the word was sent with.

The transmit half is a two-state machine:
- TX_IDLE goes to TX_SHIFT when a word is accepted.
- TX_SHIFT stays in TX_SHIFT for each inner bit-time.
- TX_SHIFT reloads and stays in TX_SHIFT when a new word is accepted on the final bit-time.
- TX_SHIFT drops back to TX_IDLE after the final bit-time when no new word is taken.

The receive half is also a two-state machine:
- RX_IDLE goes to RX_GATHER on the first bit-time of a word that needs more than one bit-time.
- RX_IDLE stays in RX_IDLE when a one-beat word completes at once.
- RX_GATHER stays in RX_GATHER for inner bit-times.
- RX_GATHER returns to RX_IDLE when the final bit-time is taken.

Top module: `stripe_link`

## Requirements
- R1: After reset the transmitter is idle: `lane_tx` is 0, `lane_tx_valid` and `word_done` are low, `out_valid` is low, and `in_ready` is high while `lane_mask` is nonzero.
- R2: With K lit lanes, word bit i appears on the (i mod K)-th lit lane, counted in ascending lane index, during bit-time floor(i/K) after acceptance.
- R3: A lane whose mask bit is 0 outputs 0 at all times. On the final bit-time, a lit lane whose bit index is N or more outputs 0. All lanes are 0 while `lane_tx_valid` is low.
- R4: A word occupies exactly ceil(N/K) consecutive bit-times. `lane_tx_valid` is high on each of them, and `word_done` is high on the last one only. The first bit-time is the cycle after the accepting edge.
- R5: `in_ready` is high only when the transmitter is idle or on the final bit-time of a word, and only if `lane_mask` is nonzero. This allows back-to-back words with no gap.
- R6: `lane_mask` is sampled only on the accepting edge. Changing it while a word is in flight does not alter that word's lane outputs.
- R7: While `lane_mask` is all zero, `cfg_error` is high and `in_ready` is low, so no word is accepted.
- R8: The receiver, fed `lane_tx`/`lane_tx_valid` and the word's mask on `rx_mask`, raises `out_valid` for one cycle with `out_data` equal to the sent word. This happens in the cycle after the word's final bit-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_mask | input | LANES | Transmit lane enable mask, sampled when a word is accepted |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Transmitter can accept a word this cycle |
| in_data | input | DATA_W | Parallel word from the core |
| cfg_error | output | 1 | Mask has no lit lane |
| lane_tx | output | LANES | One OOK bit per lane per bit-time |
| lane_tx_valid | output | 1 | A bit-time of a word is on the lanes |
| word_done | output | 1 | Final bit-time of the current word |
| rx_mask | input | LANES | Mask of the word arriving at the receiver |
| lane_rx | input | LANES | Received lane bits |
| lane_rx_valid | input | 1 | Received bit-time strobe |
| out_valid | output | 1 | Rebuilt word available (one-cycle pulse) |
| out_data | output | DATA_W | Rebuilt word |

## Verification
The bench goes after these corner cases:

- **A lit count that does not divide the word width.** With three of four lanes lit on a 10-bit word, the last bit-time is partly padding. A design that miscounts bit-times would drop bit 9 or add a fifth beat. A design that leaks stale bits onto the padding lanes would light them.
- **Single-lane words and all-lane words.** These are the longest and shortest words. They expose off-by-one errors in the remaining-bit count.
- **Sparse masks such as 1010.** An error in rank assignment would swap bits between lanes.
- **Back-to-back acceptance on the final bit-time.** This catches a ready signal that opens a cycle late or a cycle early.
- **A mask changed every cycle during flight.** A design that reads the live mask would scramble the word.
- **An empty mask with valid held high.** This catches a transmitter that would take a word it cannot send.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_GATHER
    } rx_state_e;

endpackage

// File: rtl/lane_rank_map.sv
// Prefix count over a lane mask: each lane's rank among lit lanes, plus total.
module lane_rank_map #(
    parameter int LANES = 4,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]    mask,
    output logic [LANES*CW-1:0] rank_flat,
    output logic [CW-1:0]       count
);

    logic [CW-1:0] prefix [LANES+1];

    assign prefix[0] = '0;

    for (genvar g = 0; g < LANES; g++) begin : g_prefix
        assign prefix[g+1]            = prefix[g] + CW'(mask[g]);
        assign rank_flat[g*CW +: CW]  = prefix[g];
    end

    assign count = prefix[LANES];

endmodule

// File: rtl/stripe_tx.sv
// Transmit half: deals a latched word across lit lanes, K bits per bit-time.
module stripe_tx
    import stripe_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_mask,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              cfg_error,
    output logic [LANES-1:0]  lane_tx,
    output logic              lane_tx_valid,
    output logic              word_done
);

    localparam int CW = $clog2(LANES + 1);
    localparam int RW = $clog2(DATA_W + 1);

    tx_state_e         state_q;
    logic [DATA_W-1:0] word_q;
    logic [LANES-1:0]  mask_q;
    logic [RW-1:0]     rem_q;

    logic [LANES*CW-1:0] rank_flat;
    logic [CW-1:0]       lit_cnt;
    logic                last_beat;
    logic                accept;

    lane_rank_map #(.LANES(LANES), .CW(CW)) u_rank (
        .mask      (mask_q),
        .rank_flat (rank_flat),
        .count     (lit_cnt)
    );

    // Final bit-time once the bits still to send fit in one beat.
    assign last_beat = (state_q == TX_SHIFT) && (int'(lit_cnt) >= int'(rem_q));
    assign accept    = in_valid && in_ready;

    // State register and word datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            mask_q  <= '0;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (accept) begin
                        state_q <= TX_SHIFT;
                        word_q  <= in_data;
                        mask_q  <= lane_mask;
                        rem_q   <= RW'(DATA_W);
                    end
                end
                TX_SHIFT: begin
                    if (accept) begin
                        word_q  <= in_data;
                        mask_q  <= lane_mask;
                        rem_q   <= RW'(DATA_W);
                    end else if (last_beat) begin
                        state_q <= TX_IDLE;
                    end else begin
                        word_q  <= word_q >> lit_cnt;
                        rem_q   <= rem_q - RW'(lit_cnt);
                    end
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        logic [DATA_W-1:0] shifted;
        cfg_error     = ~|lane_mask;
        in_ready      = ((state_q == TX_IDLE) || last_beat) && (|lane_mask);
        lane_tx_valid = (state_q == TX_SHIFT);
        word_done     = last_beat;
        for (int l = 0; l < LANES; l++) begin
            shifted    = word_q >> rank_flat[l*CW +: CW];
            lane_tx[l] = lane_tx_valid && mask_q[l] && shifted[0];
        end
    end

endmodule

// File: rtl/stripe_rx.sv
// Receive half: gathers lit-lane bits in rank order back into the word.
module stripe_rx
    import stripe_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  rx_mask,
    input  logic [LANES-1:0]  lane_rx,
    input  logic              lane_rx_valid,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int CW = $clog2(LANES + 1);
    localparam int RW = $clog2(DATA_W + 1);

    rx_state_e         state_q;
    logic [LANES-1:0]  mask_q;
    logic [RW-1:0]     pos_q;
    logic [DATA_W-1:0] acc_q;

    logic [LANES-1:0]    eff_mask;
    logic [LANES*CW-1:0] rank_flat;
    logic [CW-1:0]       lit_cnt;
    logic [LANES-1:0]    gathered;
    logic [DATA_W-1:0]   gathered_w;
    logic [RW-1:0]       pos;
    logic [DATA_W-1:0]   merged;
    logic                beat;
    logic                word_end;

    // The first beat of a word takes the live mask; later beats the held one.
    assign eff_mask = (state_q == RX_IDLE) ? rx_mask : mask_q;

    lane_rank_map #(.LANES(LANES), .CW(CW)) u_rank (
        .mask      (eff_mask),
        .rank_flat (rank_flat),
        .count     (lit_cnt)
    );

    always_comb begin
        gathered = '0;
        for (int r = 0; r < LANES; r++) begin
            for (int l = 0; l < LANES; l++) begin
                if (eff_mask[l] && (rank_flat[l*CW +: CW] == CW'(r))) begin
                    gathered[r] = lane_rx[l];
                end
            end
        end
        gathered_w              = '0;
        gathered_w[LANES-1:0]   = gathered;
        pos      = (state_q == RX_IDLE) ? '0 : pos_q;
        merged   = ((state_q == RX_IDLE) ? '0 : acc_q) | (gathered_w << pos);
        beat     = lane_rx_valid && (lit_cnt != '0);
        word_end = (int'(pos) + int'(lit_cnt)) >= DATA_W;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            mask_q    <= '0;
            pos_q     <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (beat) begin
                if (word_end) begin
                    state_q   <= RX_IDLE;
                    out_valid <= 1'b1;
                    out_data  <= merged;
                end else begin
                    state_q   <= RX_GATHER;
                    mask_q    <= eff_mask;
                    pos_q     <= pos + RW'(lit_cnt);
                    acc_q     <= merged;
                end
            end
        end
    end

endmodule

// File: rtl/stripe_link.sv
// Top: lane-striped transmitter and matching receiver.
module stripe_link #(
    parameter int DATA_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_mask,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              cfg_error,
    output logic [LANES-1:0]  lane_tx,
    output logic              lane_tx_valid,
    output logic              word_done,
    input  logic [LANES-1:0]  rx_mask,
    input  logic [LANES-1:0]  lane_rx,
    input  logic              lane_rx_valid,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    stripe_tx #(.DATA_W(DATA_W), .LANES(LANES)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_mask     (lane_mask),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .cfg_error     (cfg_error),
        .lane_tx       (lane_tx),
        .lane_tx_valid (lane_tx_valid),
        .word_done     (word_done)
    );

    stripe_rx #(.DATA_W(DATA_W), .LANES(LANES)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_mask       (rx_mask),
        .lane_rx       (lane_rx),
        .lane_rx_valid (lane_rx_valid),
        .out_valid     (out_valid),
        .out_data      (out_data)
    );

endmodule

// File: rtl/stripe_link_checks.sv
module stripe_link_checks #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             cfg_error,
    input logic [LANES-1:0] lane_tx,
    input logic             lane_tx_valid,
    input logic             word_done,
    input logic             lane_rx_valid,
    input logic             out_valid
);

    assert_dark_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_tx_valid |-> (lane_tx == '0));

    assert_done_inside_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> lane_tx_valid);

    assert_word_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_tx_valid && !word_done) |=> lane_tx_valid);

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_tx_valid && !word_done) |-> !in_ready);

    assert_refuse_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !in_ready);

    assert_out_follows_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lane_rx_valid));

endmodule

bind stripe_link stripe_link_checks #(.LANES(LANES)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .cfg_error     (cfg_error),
    .lane_tx       (lane_tx),
    .lane_tx_valid (lane_tx_valid),
    .word_done     (word_done),
    .lane_rx_valid (lane_rx_valid),
    .out_valid     (out_valid)
);

// File: tb/stripe_link_test.sv
module stripe_link_test;

    localparam int N = 10;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [L-1:0] lane_mask = '1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_data = '0;
    logic         cfg_error;
    logic [L-1:0] lane_tx;
    logic         lane_tx_valid;
    logic         word_done;
    logic [L-1:0] rx_mask = '1;
    logic         out_valid;
    logic [N-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state.
    bit           m_busy = 0;
    logic [N-1:0] m_word = '0;
    logic [L-1:0] m_mask = '0;
    int           m_k = 0;
    int           m_beat = 0;
    int           m_beats = 0;
    bit           exp_out_valid = 0;
    logic [N-1:0] exp_out_data = '0;
    int           sent = 0;
    int           recv = 0;

    always #10 clk = ~clk;

    stripe_link #(.DATA_W(N), .LANES(L)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_mask     (lane_mask),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .cfg_error     (cfg_error),
        .lane_tx       (lane_tx),
        .lane_tx_valid (lane_tx_valid),
        .word_done     (word_done),
        .rx_mask       (rx_mask),
        .lane_rx       (lane_tx),
        .lane_rx_valid (lane_tx_valid),
        .out_valid     (out_valid),
        .out_data      (out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [L-1:0] m);
        int c = 0;
        for (int i = 0; i < L; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [L-1:0] exp_lanes();
        logic [L-1:0] v = '0;
        int r = 0;
        if (!m_busy) return v;
        for (int l = 0; l < L; l++) begin
            if (m_mask[l]) begin
                int idx = m_beat * m_k + r;
                v[l] = (idx < N) ? m_word[idx] : 1'b0;
                r++;
            end
        end
        return v;
    endfunction

    // One cycle: called at a falling edge, returns at the next falling edge.
    task automatic step(input logic v, input logic [N-1:0] d, input logic [L-1:0] m);
        bit exp_ready;
        bit last_now;
        chk("R4 lane_tx_valid", 32'(lane_tx_valid), 32'(m_busy));
        chk("R4 word_done", 32'(word_done), 32'(m_busy && (m_beat == m_beats - 1)));
        chk("R2/R3/R6 lane_tx", 32'(lane_tx), 32'(exp_lanes()));
        chk("R8 out_valid", 32'(out_valid), 32'(exp_out_valid));
        if (exp_out_valid) begin
            chk("R8 out_data", 32'(out_data), 32'(exp_out_data));
            recv++;
        end
        in_valid  = v;
        in_data   = d;
        lane_mask = m;
        #1;
        exp_ready = (!m_busy || (m_beat == m_beats - 1)) && (m != '0);
        chk("R5/R7 in_ready", 32'(in_ready), 32'(exp_ready));
        chk("R7 cfg_error", 32'(cfg_error), 32'(m == '0));
        last_now      = m_busy && (m_beat == m_beats - 1);
        exp_out_valid = last_now;
        exp_out_data  = m_word;
        if (v && exp_ready) begin
            m_busy  = 1;
            m_word  = d;
            m_mask  = m;
            m_k     = popc(m);
            m_beats = (N + m_k - 1) / m_k;
            m_beat  = 0;
            sent++;
        end else if (m_busy) begin
            if (last_now) m_busy = 0;
            else m_beat++;
        end
        rx_mask = m_mask;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] rm;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk("R1 lane_tx", 32'(lane_tx), 32'h0);
        chk("R1 lane_tx_valid", 32'(lane_tx_valid), 32'h0);
        chk("R1 word_done", 32'(word_done), 32'h0);
        chk("R1 out_valid", 32'(out_valid), 32'h0);
        chk("R1 in_ready", 32'(in_ready), 32'h1);
        @(negedge clk);

        // All lanes, back-to-back (R4, R5).
        for (int i = 0; i < 12; i++) step(1'b1, N'(10'h2A5 + i * 37), 4'b1111);
        // Single lane: longest word.
        for (int i = 0; i < 25; i++) step(1'b1, N'(10'h3C1 ^ (i * 91)), 4'b0001);
        // Sparse mask.
        for (int i = 0; i < 12; i++) step(1'b1, N'(10'h155 + i * 13), 4'b1010);
        // Three lanes: padding on last beat (R3).
        for (int i = 0; i < 12; i++) step(1'b1, N'(10'h3FF - i * 29), 4'b0111);
        for (int i = 0; i < 6; i++) step(1'b0, '0, 4'b1111);
        // Empty mask with valid held (R7).
        for (int i = 0; i < 6; i++) step(1'b1, N'(10'h1E3), 4'b0000);
        step(1'b1, N'(10'h2D9), 4'b0100);
        for (int i = 0; i < 12; i++) step(1'b0, '0, 4'b0000);
        // Mask flips during flight (R6).
        step(1'b1, N'(10'h26B), 4'b1011);
        for (int i = 0; i < 8; i++) step(1'b0, '0, L'(i * 5 + 1));
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            rm = L'($urandom);
            step(($urandom % 4) != 0, N'($urandom), rm);
        end
        for (int i = 0; i < 16; i++) step(1'b0, '0, 4'b1111);
        chk("R8 words recovered", 32'(recv), 32'(sent));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule